// File: doc/BRIEF.md
# Dual-Channel Input Capture Unit

This block timestamps edges on two external inputs. A 16-bit timer comes in from outside and keeps running. Each channel watches its own input pin and, on a qualifying event, stores the timer value in a capture register. Software reads that register as two bytes over a small synchronous register bus. Each channel picks its own qualifying event. It can capture on falling edges, on rising edges, or on every fourth or sixteenth rising edge, counted by a prescaler.

A channel that holds an unread value does not overwrite it. When a further event arrives before software has finished reading, the channel raises its overflow flag. The stored value stays as it was until software reads the low byte and then the high byte. That read clears the flag and lets the channel capture again. One byte-wide control/status register holds both mode fields, both overflow flags and an enable bit, which drives a pin to a PWM generator outside this block.

Top module: `dual_capture_unit`

## Requirements
- R1: After reset the control/status register reads 0x00, all four capture byte registers read 0x00 and `pwm_en` is 0.
- R2: The control/status register is at address 0 and has this layout:
  - bit 0 is the PWM enable and drives `pwm_en`;
  - bits 2:1 are the channel A mode;
  - bits 4:3 are the channel B mode;
  - bit 5 is the channel A overflow flag;
  - bit 6 is the channel B overflow flag;
  - bit 7 always reads 0.

  A write updates only bits 4:0. Writing 0xFF therefore reads back as 0x1F.
- R3: In mode 01 a channel captures on every rising edge of its input. Channel A's low and high bytes are at addresses 1 and 2. Channel B's low and high bytes are at addresses 3 and 4.
- R4: In mode 00 a channel captures on every falling edge of its input and ignores rising edges.
- R5: In mode 10 a channel captures on every 4th rising edge after the mode was written.
- R6: In mode 11 a channel captures on every 16th rising edge after the mode was written.
- R7: If a capture event occurs while the channel holds an unread value, the channel sets its overflow flag. The capture registers keep the earlier value, and later events do not change them.
- R8: A channel is re-armed only by a strobed read of its low byte followed by a strobed read of its high byte. That sequence clears both the overflow flag and the unread state. A strobed read of the high byte alone changes nothing.
- R9: Read data is combinational on `addr`. Reads without `rd_stb` have no side effects on the flags or on re-arming.
- R10: Any write to the control/status register restarts both prescale counts from zero.
- R11: The two channels operate independently: events, reads and flags of one channel do not affect the other.
- R12: The stored value is the `timer_val` present at the second rising clock edge after the edge that first samples the new input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_val | input | 16 | Free-running timer value |
| cap_in | input | 2 | Asynchronous capture inputs; bit 0 is channel A, bit 1 is channel B |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe; read side effects occur only when it is high |
| rd_data | output | 8 | Read data for `addr` |
| pwm_en | output | 1 | PWM enable bit out to the PWM generator |

## Verification
The bench targets the following corner cases.

- **Overwrite on a second event.** A design that overwrites would show a newer timer value after the second pulse instead of the first one.
- **Clearing on the high byte alone.** A design that clears the flag on a high-byte-only read would show the overflow flag dropping too early.
- **Prescaler restart on a control write.** A prescaler that is not cleared by a control write would capture two pulses too soon.
- **Side effects without the strobe.** Reads without the strobe must not count toward re-arming, and the bench checks that they do not.
- **Both channels at once.** Both channels are stimulated together in different modes. Crossed enables or crossed byte addresses show up as a mismatch against the cycle-accurate model.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the dual-channel capture unit.
// Assumes a 16-bit timer read as two bytes and a 3-bit register address.
package cap_pkg;
    localparam int TIMER_W  = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_CH   = 2;
    localparam int ADDR_W   = 3;
    localparam int DIV_LO   = 4;
    localparam int DIV_HI   = 16;
    localparam int PS_W     = $clog2(DIV_HI);

    typedef enum logic [1:0] {
        CM_FALL   = 2'b00,
        CM_RISE   = 2'b01,
        CM_RISE4  = 2'b10,
        CM_RISE16 = 2'b11
    } cap_mode_e;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;
endpackage

// File: rtl/cap_edge_sync.sv
`timescale 1ns/1ps
// Synchronizes one asynchronous input and gives one-cycle edge pulses.
// Assumes STAGES >= 2; the input may change at any time.
module cap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the input through the synchronizer and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise); // R3
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall); // R4
endmodule

// File: rtl/cap_prescale.sv
`timescale 1ns/1ps
// Turns raw edges into capture events according to the channel mode.
// Assumes clr is one cycle wide on each control write; clr wins over counting.
module cap_prescale
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cap_mode_e mode,
    input  logic      rise,
    input  logic      fall,
    input  logic      clr,
    output logic      fire
);
    logic [PS_W-1:0] cnt_q;
    logic            counting;
    logic            at_term;

    // Select the terminal count for the divided modes.
    always_comb begin
        counting = (mode == CM_RISE4) || (mode == CM_RISE16);
        at_term  = (mode == CM_RISE4) ? (cnt_q == PS_W'(DIV_LO - 1))
                                      : (cnt_q == PS_W'(DIV_HI - 1));
    end

    // Decode the qualifying event for the current mode.
    always_comb begin
        case (mode)
            CM_FALL:  fire = fall;
            CM_RISE:  fire = rise;
            default:  fire = rise && at_term;
        endcase
    end

    // Count rising edges in divided modes; restart on terminal count or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (counting && rise) begin
            cnt_q <= at_term ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (cnt_q == '0)); // R10
    AST_DIV4_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_RISE4) |-> (cnt_q < PS_W'(DIV_LO))); // R5
endmodule

// File: rtl/cap_channel.sv
`timescale 1ns/1ps
// One capture register with unread tracking, overflow lockout and
// low-then-high read detection. Assumes rd_lo and rd_hi are never both high.
module cap_channel
    import cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] timer,
    input  logic               fire,
    input  logic               rd_lo,
    input  logic               rd_hi,
    output logic [TIMER_W-1:0] cap_val,
    output logic               ovf
);
    logic [TIMER_W-1:0] cap_q;
    logic               valid_q;
    logic               ovf_q;
    logic               low_seen_q;
    logic               pair_done;

    assign pair_done = rd_hi && low_seen_q;

    // Track that the low byte was read, so a following high read completes the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_seen_q <= 1'b0;
        end else if (rd_lo) begin
            low_seen_q <= 1'b1;
        end else if (pair_done) begin
            low_seen_q <= 1'b0;
        end
    end

    // Capture when free, flag overflow when the value is still unread, re-arm on pair read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= '0;
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (fire && valid_q && !pair_done) begin
            ovf_q   <= 1'b1;
        end else if (fire) begin
            cap_q   <= timer;
            valid_q <= 1'b1;
            ovf_q   <= 1'b0;
        end else if (pair_done) begin
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
        end
    end

    assign cap_val = cap_q;
    assign ovf     = ovf_q;

    AST_HOLD_WHILE_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !pair_done) |=> $stable(cap_q)); // R7
    AST_OVF_NEEDS_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(valid_q)); // R7
    AST_PAIR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |=> !ovf_q); // R8
    AST_CAPTURE_TAKES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !valid_q) |=> (valid_q && cap_q == $past(timer))); // R3
endmodule

// File: rtl/dual_capture_unit.sv
`timescale 1ns/1ps
// Two input-capture channels sharing one external timer, with a byte-wide
// control/status register and a synchronous register bus.
// Assumes addr, wr_en and rd_stb are synchronous to clk; reads are side-effect free
// unless rd_stb is high.
module dual_capture_unit
    import cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] timer_val,
    input  logic [NUM_CH-1:0]  cap_in,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               rd_stb,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               pwm_en
);
    cap_mode_e          mode_q [NUM_CH];
    logic               pwm_q;
    logic               ctrl_wr;
    logic [TIMER_W-1:0] cap_val [NUM_CH];
    logic [NUM_CH-1:0]  ovf;

    assign ctrl_wr = wr_en && (addr == ADDR_CTRL);

    // Hold the writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q     <= 1'b0;
            mode_q[0] <= CM_FALL;
            mode_q[1] <= CM_FALL;
        end else if (ctrl_wr) begin
            pwm_q     <= wr_data[0];
            mode_q[0] <= cap_mode_e'(wr_data[2:1]);
            mode_q[1] <= cap_mode_e'(wr_data[4:3]);
        end
    end

    assign pwm_en = pwm_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(1 + 2 * ch);
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 + 2 * ch);
        logic rise, fall, fire, rd_lo, rd_hi;

        assign rd_lo = rd_stb && (addr == LO_ADDR);
        assign rd_hi = rd_stb && (addr == HI_ADDR);

        cap_edge_sync #(.STAGES(2)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cap_in[ch]),
            .rise (rise),
            .fall (fall)
        );

        cap_prescale u_ps (
            .clk  (clk),
            .rst_n(rst_n),
            .mode (mode_q[ch]),
            .rise (rise),
            .fall (fall),
            .clr  (ctrl_wr),
            .fire (fire)
        );

        cap_channel u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .timer  (timer_val),
            .fire   (fire),
            .rd_lo  (rd_lo),
            .rd_hi  (rd_hi),
            .cap_val(cap_val[ch]),
            .ovf    (ovf[ch])
        );
    end

    // Return the addressed register; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_CTRL) begin
            rd_data = {1'b0, ovf[1], ovf[0], mode_q[1], mode_q[0], pwm_q};
        end else begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (addr == ADDR_W'(1 + 2 * ch)) rd_data = cap_val[ch][BYTE_W-1:0];
                if (addr == ADDR_W'(2 + 2 * ch)) rd_data = cap_val[ch][TIMER_W-1:BYTE_W];
            end
        end
    end

    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_CTRL) |-> (rd_data[7] == 1'b0)); // R2
    AST_PWM_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (pwm_en == $past(wr_data[0]))); // R2
endmodule

// File: tb/tb_dual_capture_unit.sv
`timescale 1ns/1ps
module tb_dual_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = 16'h1234;
    logic [1:0]  cap_in = 2'b00;
    logic [2:0]  addr = 3'd0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;
    logic        pwm_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit mon_on = 0;

    always #2 clk = ~clk;

    dual_capture_unit dut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_in(cap_in),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_stb(rd_stb),
        .rd_data(rd_data), .pwm_en(pwm_en)
    );

    // ---------------- behavioural reference model ----------------
    int          m_mode [2];
    int          m_cnt [2];
    bit          m_valid [2];
    bit          m_ovf [2];
    bit          m_low [2];
    logic [15:0] m_cap [2];
    bit          m_pwm;
    logic [1:0]  hist [$];

    function automatic logic [1:0] hget(int k);
        return (k < hist.size()) ? hist[k] : 2'b00;
    endfunction

    function automatic logic [7:0] model_read(logic [2:0] a);
        case (a)
            3'd0: return {1'b0, m_ovf[1], m_ovf[0], m_mode[1][1:0], m_mode[0][1:0], m_pwm};
            3'd1: return m_cap[0][7:0];
            3'd2: return m_cap[0][15:8];
            3'd3: return m_cap[1][7:0];
            3'd4: return m_cap[1][15:8];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_mode[c] = 0; m_cnt[c] = 0; m_valid[c] = 0;
                m_ovf[c] = 0; m_low[c] = 0; m_cap[c] = 16'h0;
            end
            m_pwm = 0;
            hist.delete();
        end else begin
            bit wr;
            wr = wr_en && (addr == 3'd0);
            for (int c = 0; c < 2; c++) begin
                bit r, f, fire, rlo, rhi, pd;
                int term;
                r = hget(1)[c] && !hget(2)[c];
                f = !hget(1)[c] && hget(2)[c];
                term = (m_mode[c] == 2) ? 3 : 15;
                if (m_mode[c] == 0) fire = f;
                else if (m_mode[c] == 1) fire = r;
                else fire = r && (m_cnt[c] == term);
                if (wr) m_cnt[c] = 0;
                else if (r && m_mode[c] >= 2) m_cnt[c] = fire ? 0 : m_cnt[c] + 1;
                rlo = rd_stb && (addr == 3'(1 + 2 * c));
                rhi = rd_stb && (addr == 3'(2 + 2 * c));
                pd = rhi && m_low[c];
                if (rlo) m_low[c] = 1; else if (pd) m_low[c] = 0;
                if (fire && m_valid[c] && !pd) m_ovf[c] = 1;
                else if (fire) begin m_cap[c] = timer_val; m_valid[c] = 1; m_ovf[c] = 0; end
                else if (pd) begin m_valid[c] = 0; m_ovf[c] = 0; end
            end
            if (wr) begin
                m_pwm = wr_data[0];
                m_mode[0] = int'(wr_data[2:1]);
                m_mode[1] = int'(wr_data[4:3]);
            end
            hist.push_front(cap_in);
            if (hist.size() > 4) void'(hist.pop_back());
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison of the visible register and pwm_en against the model.
    always @(posedge clk) begin
        #1;
        if (mon_on && rst_n && !done) begin
            chk("R2 R7 per-cycle view", rd_data, model_read(addr));
            chk("R2 pwm_en per-cycle", {7'b0, pwm_en}, {7'b0, m_pwm});
        end
    end

    always @(negedge clk) timer_val <= timer_val + 16'd7;

    task automatic wr_ctrl(logic [7:0] d);
        @(negedge clk);
        addr = 3'd0; wr_en = 1'b1; wr_data = d;
        @(posedge clk); #0.5;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, bit stb, string req);
        @(negedge clk);
        addr = a; rd_stb = stb;
        #0.5;
        chk(req, rd_data, model_read(a));
        @(posedge clk); #0.5;
        rd_stb = 1'b0; addr = 3'd0;
    endtask

    task automatic rd_const(logic [2:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        addr = a;
        #0.5;
        chk(req, rd_data, exp);
        @(posedge clk); #0.5;
        addr = 3'd0;
    endtask

    task automatic pulse(int ch, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cap_in[ch] = 1'b1;
            repeat (3) @(negedge clk);
            cap_in[ch] = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] lo_a, hi_a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        // R1: reset state
        for (int a = 0; a < 5; a++) rd_const(3'(a), 8'h00, "R1 reset value");
        chk("R1 pwm_en reset", {7'b0, pwm_en}, 8'h00);

        // R2: layout, read-only bits
        wr_ctrl(8'hFF);
        rd_const(3'd0, 8'h1F, "R2 write FF reads 1F");
        chk("R2 pwm_en set", {7'b0, pwm_en}, 8'h01);

        // R3/R4: A rising (01), B falling (00)
        wr_ctrl(8'h03);
        pulse(0, 1);
        settle();
        rd(3'd1, 1, "R3 R12 chA low byte");
        lo_a = rd_data;
        rd(3'd2, 1, "R3 R12 chA high byte");
        cap_in[1] = 1'b1;
        settle();
        rd_const(3'd3, 8'h00, "R4 chB ignores rising edge");
        cap_in[1] = 1'b0;
        settle();
        rd(3'd3, 1, "R4 chB low byte on falling");
        rd(3'd4, 1, "R4 chB high byte on falling");

        // R7/R8/R9: overflow lockout and read sequence on channel A
        pulse(0, 1);
        settle();
        rd(3'd1, 0, "R7 first capture low");
        lo_a = rd_data;
        rd(3'd2, 0, "R7 first capture high");
        hi_a = rd_data;
        pulse(0, 2);
        settle();
        rd_const(3'd0, 8'h23, "R7 overflow flag A set");
        rd_const(3'd1, lo_a, "R7 low byte kept");
        rd_const(3'd2, hi_a, "R7 high byte kept");
        rd(3'd2, 1, "R8 high-only read");
        rd_const(3'd0, 8'h23, "R8 flag survives high-only read");
        rd(3'd1, 0, "R9 low read without strobe");
        rd(3'd2, 1, "R9 high read after unstrobed low");
        rd_const(3'd0, 8'h23, "R9 unstrobed read has no effect");
        rd(3'd1, 1, "R8 low read");
        rd(3'd2, 1, "R8 high read completes pair");
        rd_const(3'd0, 8'h03, "R8 flag cleared");
        pulse(0, 1);
        settle();
        rd(3'd1, 1, "R8 re-armed capture low");
        rd(3'd2, 1, "R8 re-armed capture high");

        // R5: divide by 4 on A
        wr_ctrl(8'h05);
        pulse(0, 3);
        settle();
        rd_const(3'd0, 8'h05, "R5 no capture after 3 edges");
        pulse(0, 1);
        settle();
        rd(3'd1, 1, "R5 capture on 4th edge low");
        rd(3'd2, 1, "R5 capture on 4th edge high");
        pulse(0, 4);
        settle();
        rd(3'd1, 1, "R5 capture on 8th edge low");
        rd(3'd2, 1, "R5 capture on 8th edge high");

        // R10: control write restarts the count
        pulse(0, 2);
        wr_ctrl(8'h05);
        pulse(0, 2);
        settle();
        rd_const(3'd0, 8'h05, "R10 restart delays capture");
        pulse(0, 2);
        settle();
        rd(3'd1, 1, "R10 capture after restart low");
        rd(3'd2, 1, "R10 capture after restart high");

        // R6: divide by 16 on B, R11: A rising at the same time
        wr_ctrl(8'h1A);
        fork
            pulse(1, 15);
            pulse(0, 1);
        join
        settle();
        rd(3'd0, 0, "R6 R11 status after 15 edges");
        rd(3'd1, 1, "R11 chA low");
        rd(3'd2, 1, "R11 chA high");
        rd(3'd3, 0, "R6 chB unchanged low");
        pulse(1, 1);
        settle();
        rd(3'd3, 1, "R6 chB 16th edge low");
        rd(3'd4, 1, "R6 chB 16th edge high");
        rd(3'd0, 0, "R11 final status");
        finish_run();
    end
endmodule